// File: doc/BRIEF.md
# T1 Transmit Frame Formatter

This block builds the outgoing T1 bitstream in extended-superframe form. It takes a serial stream of 193-bit frames, one bit per clock, each made of a framing-bit slot followed by 24 eight-bit channels sent most significant bit first. A frame-sync pulse marks the framing bit of frame 1 of each 24-frame superframe. The block produces the transmitted stream on a serial output exactly eight clocks later.

On the way through, the framing-bit slots are filled. The framing pattern, the CRC6 check bits and the data-link bits come from internal sources, or from the input when pass-through controls are set. The least significant bit of enabled channels can be replaced by robbed-bit signaling from a signaling table. Channel bytes that end up all zero can have bit 7 forced to one. Yellow and blue alarms are generated on request.

Mode bits, per-channel masks, the data-link word and the signaling table are plain input ports. They are meant to change only at superframe boundaries.

Top module: `t1_tx_formatter`

## Requirements
- R1: After `fsync` is high with the framing bit of frame 1, every input bit appears on `ser_out` 8 clocks after it is sampled. Payload bits not touched by R7 to R11 pass unchanged. `ser_out` is 0 after reset and stays 0 until the first `fsync`.
- R2: With `f_pass`=0, the framing bits of frames 4, 8, 12, 16, 20 and 24 (frames numbered 1 to 24 from the sync) carry 0,0,1,0,1,1 in that order.
- R3: With `crc_pass`=0, the framing bits of frames 2, 6, 10, 14, 18 and 22 carry the CRC6 remainder, most significant bit first. The remainder uses x^6+x+1 with a zero start value and is taken over the whole previous transmitted superframe, with every framing bit counted as 1. The first superframe after reset carries zeros.
- R4: With `f_pass`=1, the framing-pattern and data-link slots carry the input bit sampled in that slot.
- R5: With `crc_pass`=1, the CRC slots carry the input bit sampled in that slot.
- R6: In the data-link slots of odd frames 2i+1, the output carries `dl_word[i]` when `dl_sel`=0. When `dl_sel`=1 it carries `dl_ext` sampled in that slot.
- R7: When `sig_en`=1 and `sig_mask[c]`=1, the last bit of channel c in frames 6, 12, 18 and 24 is replaced by `sig_val[4c+3]`, `[4c+2]`, `[4c+1]` and `[4c]` respectively. Otherwise that bit passes.
- R8: With `gstuff`=0, a channel byte that is all zero after R7 and whose `stuff_mask` bit is set goes out with bit 7 (the second-to-last bit sent) at 1. Nonzero bytes and unmasked channels are never altered.
- R9: With `gstuff`=1, every all-zero channel byte is stuffed as in R8, whatever `stuff_mask` holds.
- R10: While `yel_en`=1 and `f_pass`=0, the data-link slots carry a repeating pattern of eight 0s then eight 1s, taking precedence over R6. The pattern restarts with the zeros each time `yel_en` rises.
- R11: While `blue_en`=1, every output bit, framing slots included, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial frame input |
| fsync | input | 1 | High with the framing bit of frame 1 |
| f_pass | input | 1 | Framing and data-link slots from input |
| crc_pass | input | 1 | CRC slots from input |
| sig_en | input | 1 | Signaling insertion enable |
| gstuff | input | 1 | Stuff every all-zero byte |
| dl_sel | input | 1 | Data-link source: 0 word, 1 external bit |
| blue_en | input | 1 | Send unframed all ones |
| yel_en | input | 1 | Send yellow alarm pattern |
| dl_ext | input | 1 | External data-link bit |
| dl_word | input | 12 | Internal data-link bits, one per odd frame |
| stuff_mask | input | 24 | Per-channel stuffing enable |
| sig_mask | input | 24 | Per-channel signaling enable |
| sig_val | input | 96 | Signaling nibbles, A in the top bit of each |
| ser_out | output | 1 | Transmitted serial stream |

## Verification
The bench runs seven consecutive superframes, each with a different mode mix, so that every framing-slot source is used at least once. In every superframe, channels cycle through all-zero bytes, bytes with only the last bit set, bytes with only the first bit set, and random bytes. This separates stuffing on truly zero bytes, stuffing caused by signaling clearing the last bit, and untouched nonzero bytes. The yellow alarm is held for two superframes, so the sixteen-bit pattern crosses a superframe edge. The superframe sent after the blue alarm confirms that the CRC is taken from the all-ones stream actually sent.

// File: rtl/t1f_pkg.sv
// Package: shared constants for the T1 transmit formatter.
// Assumes extended superframe of 24 frames of 193 bits.
package t1f_pkg;
    localparam int FRAME_BITS = 193;
    localparam int N_CH       = 24;
    localparam int N_FRM      = 24;
    localparam int CRC_W      = 6;
    localparam int DL_BITS    = 12;
    localparam int SIG_W      = 4;
    localparam int BYTE_W     = 8;
    // Framing pattern, bit k is the k-th pattern bit (0,0,1,0,1,1)
    localparam logic [5:0] FPS_PAT  = 6'b110100;
    // Low terms of x^6 + x + 1
    localparam logic [5:0] CRC_POLY = 6'b000011;
endpackage

// File: rtl/t1f_timing.sv
// Module: t1f_timing
// Tracks bit position within a frame and frame number within a superframe.
// Assumes fsync is high on the framing bit of frame 1; it realigns counters
// whenever asserted. Nothing is active before the first fsync.
module t1f_timing #(
    parameter int FBITS = t1f_pkg::FRAME_BITS,
    parameter int NFRM  = t1f_pkg::N_FRM,
    parameter int NCH   = t1f_pkg::N_CH,
    localparam int PW   = $clog2(FBITS),
    localparam int FW   = $clog2(NFRM),
    localparam int CW   = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic          active,
    output logic          f_slot,
    output logic          sf_start,
    output logic          lsb_slot,
    output logic [CW-1:0] ch,
    output logic [FW-1:0] frm
);
    logic [PW-1:0] pos_q, cur_pos, pm1;
    logic [FW-1:0] frm_q;
    logic          lock_q;

    // Current slot, with fsync forcing the framing bit of frame 1
    always_comb begin
        cur_pos  = fsync ? '0 : pos_q;
        frm      = fsync ? '0 : frm_q;
        active   = fsync | lock_q;
        pm1      = cur_pos - PW'(1);
        f_slot   = active && (cur_pos == '0);
        sf_start = f_slot && (frm == '0);
        lsb_slot = active && (cur_pos != '0) && (pm1[2:0] == 3'b111);
        ch       = CW'(pm1[PW-1:3]);
    end

    // Advance position and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            frm_q  <= '0;
            lock_q <= 1'b0;
        end else if (active) begin
            lock_q <= 1'b1;
            if (cur_pos == PW'(FBITS - 1)) begin
                pos_q <= '0;
                frm_q <= (frm == FW'(NFRM - 1)) ? '0 : frm + FW'(1);
            end else begin
                pos_q <= cur_pos + PW'(1);
                frm_q <= frm;
            end
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < PW'(FBITS));  // R1
    AST_FSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (pos_q == PW'(1)) && (frm_q == '0));  // R1
endmodule

// File: rtl/t1f_fsrc.sv
// Module: t1f_fsrc
// Selects the framing-bit value: pattern, CRC, data link or yellow alarm,
// each overridable by pass-through. Assumes frm counts 0..23 from the sync.
module t1f_fsrc #(
    parameter int NFRM = t1f_pkg::N_FRM,
    parameter int DLB  = t1f_pkg::DL_BITS,
    parameter int CRCW = t1f_pkg::CRC_W,
    localparam int FW  = $clog2(NFRM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            f_slot,
    input  logic [FW-1:0]   frm,
    input  logic            ser_in,
    input  logic            f_pass,
    input  logic            crc_pass,
    input  logic            dl_sel,
    input  logic            yel_en,
    input  logic            dl_ext,
    input  logic [DLB-1:0]  dl_word,
    input  logic [CRCW-1:0] crc_prev,
    output logic            fbit
);
    localparam logic [FW-3:0] KMAX = (FW-2)'(CRCW - 1);
    logic [FW-3:0] k;
    logic [FW-2:0] fi;
    logic [3:0]    ycnt_q;

    // Yellow pattern phase: cleared while idle, steps on each data-link slot
    always_ff @(posedge clk) begin
        if (!rst_n || !yel_en) ycnt_q <= '0;
        else if (f_slot && !frm[0]) ycnt_q <= ycnt_q + 4'd1;
    end

    // Source multiplexer by slot type
    always_comb begin
        k  = frm[FW-1:2];
        fi = frm[FW-1:1];
        case (frm[1:0])
            2'b11:   fbit = f_pass ? ser_in : t1f_pkg::FPS_PAT[k];
            2'b01:   fbit = crc_pass ? ser_in : crc_prev[KMAX - k];
            default: fbit = f_pass ? ser_in :
                            yel_en ? ycnt_q[3] :
                            dl_sel ? dl_ext : dl_word[fi];
        endcase
    end

    AST_YEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !yel_en |=> (ycnt_q == '0));  // R10
    AST_YEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (yel_en && !(f_slot && !frm[0])) |=> $stable(ycnt_q));  // R10
endmodule

// File: rtl/t1f_crc6.sv
// Module: t1f_crc6
// Serial CRC over the transmitted stream, framing bits counted as 1.
// Latches the finished remainder at each superframe start.
module t1f_crc6 #(
    parameter int W = t1f_pkg::CRC_W,
    parameter logic [W-1:0] POLY = t1f_pkg::CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         obit,
    input  logic         is_f,
    input  logic         is_sf,
    output logic [W-1:0] crc_prev
);
    logic [W-1:0] st_q, base, nxt;
    logic         din, fb;

    // One LFSR step from the current or a fresh state
    always_comb begin
        base = is_sf ? '0 : st_q;
        din  = is_f | obit;
        fb   = din ^ base[W-1];
        nxt  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // State and latched remainder
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            crc_prev <= '0;
        end else begin
            st_q <= nxt;
            if (is_sf) crc_prev <= st_q;
        end
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_sf |=> $stable(crc_prev));  // R3
endmodule

// File: rtl/t1_tx_formatter.sv
// Module: t1_tx_formatter (top)
// Eight-clock delay line carrying the outgoing stream; framing slots, signaling
// and bit 7 stuffing are applied as bits enter or as each byte completes.
// Assumes configuration inputs change only at superframe boundaries.
module t1_tx_formatter #(
    parameter int N_CH       = t1f_pkg::N_CH,
    parameter int N_FRM      = t1f_pkg::N_FRM,
    parameter int FRAME_BITS = t1f_pkg::FRAME_BITS,
    parameter int DL_BITS    = t1f_pkg::DL_BITS,
    localparam int SIG_W     = t1f_pkg::SIG_W,
    localparam int SV_W      = N_CH * SIG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_in,
    input  logic               fsync,
    input  logic               f_pass,
    input  logic               crc_pass,
    input  logic               sig_en,
    input  logic               gstuff,
    input  logic               dl_sel,
    input  logic               blue_en,
    input  logic               yel_en,
    input  logic               dl_ext,
    input  logic [DL_BITS-1:0] dl_word,
    input  logic [N_CH-1:0]    stuff_mask,
    input  logic [N_CH-1:0]    sig_mask,
    input  logic [SV_W-1:0]    sig_val,
    output logic               ser_out
);
    localparam int BW = t1f_pkg::BYTE_W;
    localparam int FW = $clog2(N_FRM);
    localparam int CW = $clog2(N_CH);
    localparam int NSIG = 4;

    logic          active, f_slot, sf_start, lsb_slot, fbit;
    logic [CW-1:0] ch;
    logic [FW-1:0] frm;
    logic [t1f_pkg::CRC_W-1:0] crc_prev;
    logic [BW-1:0] dl_q, mf_q, ms_q;
    logic          sig_frame, sig_ins, lsb_val, stuff, ent;
    logic [1:0]    sj;
    logic [$clog2(SV_W)-1:0] sidx;

    t1f_timing #(.FBITS(FRAME_BITS), .NFRM(N_FRM), .NCH(N_CH)) tim_i (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .active(active),
        .f_slot(f_slot), .sf_start(sf_start), .lsb_slot(lsb_slot),
        .ch(ch), .frm(frm)
    );

    t1f_fsrc #(.NFRM(N_FRM), .DLB(DL_BITS)) fsrc_i (
        .clk(clk), .rst_n(rst_n), .f_slot(f_slot), .frm(frm),
        .ser_in(ser_in), .f_pass(f_pass), .crc_pass(crc_pass),
        .dl_sel(dl_sel), .yel_en(yel_en), .dl_ext(dl_ext),
        .dl_word(dl_word), .crc_prev(crc_prev), .fbit(fbit)
    );

    t1f_crc6 crc_i (
        .clk(clk), .rst_n(rst_n), .obit(dl_q[BW-1]), .is_f(mf_q[BW-1]),
        .is_sf(ms_q[BW-1]), .crc_prev(crc_prev)
    );

    // Signaling frame detect: frames 6,12,18,24 carry A,B,C,D
    always_comb begin
        sig_frame = 1'b0;
        sj        = 2'd0;
        for (int j = 0; j < NSIG; j++) begin
            if (frm == FW'(6 * j + 5)) begin
                sig_frame = 1'b1;
                sj        = 2'(j);
            end
        end
    end

    // Last-bit value and zero-byte stuffing decision
    always_comb begin
        sidx    = {ch, 2'b11 - sj};
        sig_ins = sig_en && sig_mask[ch] && sig_frame;
        lsb_val = sig_ins ? sig_val[sidx] : ser_in;
        stuff   = lsb_slot && !blue_en && (dl_q[BW-2:0] == '0) && !lsb_val
                  && (gstuff || stuff_mask[ch]);
    end

    // Bit entering the delay line
    always_comb begin
        if (!active)       ent = 1'b0;
        else if (blue_en)  ent = 1'b1;
        else if (f_slot)   ent = fbit;
        else if (lsb_slot) ent = lsb_val;
        else               ent = ser_in;
    end

    // Delay line with framing and superframe markers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
            mf_q <= '0;
            ms_q <= '0;
        end else begin
            dl_q <= {dl_q[BW-2:1], dl_q[0] | stuff, ent};
            mf_q <= {mf_q[BW-2:0], f_slot};
            ms_q <= {ms_q[BW-2:0], sf_start};
        end
    end

    assign ser_out = dl_q[BW-1];

    AST_BLUE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (active && blue_en) |=> dl_q[0]);  // R11
    AST_FPASS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (f_slot && f_pass && !blue_en && frm[1:0] != 2'b01)
        |=> (dl_q[0] == $past(ser_in)));  // R4
    AST_SIG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lsb_slot && !sig_en && !blue_en) |=> (dl_q[0] == $past(ser_in)));  // R7
    AST_GSTUFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lsb_slot && gstuff && !blue_en && dl_q[BW-2:0] == '0 && !lsb_val)
        |=> dl_q[1]);  // R9
    AST_NZ_NOSTUFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lsb_slot && !dl_q[0] && dl_q[BW-2:1] != '0) |=> !dl_q[1]);  // R8
endmodule

// File: tb/t1_tx_formatter_tb.sv
`timescale 1ns/1ps
module t1_tx_formatter_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_in = 0, fsync = 0, f_pass = 0, crc_pass = 0, sig_en = 0, gstuff = 0;
    logic dl_sel = 0, blue_en = 0, yel_en = 0, dl_ext = 0;
    logic [11:0] dl_word = '0;
    logic [23:0] stuff_mask = '0, sig_mask = '0;
    logic [95:0] sig_val = '0;
    logic ser_out;

    // pending configuration, applied at each superframe start
    logic p_fp, p_cp, p_se, p_gs, p_ds, p_bl, p_ye;

    typedef struct { logic b; string tag; longint due; } item_t;
    item_t sbq[$];
    int n_chk = 0, n_err = 0;
    longint cyc = 0;
    logic [5:0] m_st = '0, m_prev = '0;
    logic [3:0] m_y = '0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    t1_tx_formatter dut_i (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fsync(fsync),
        .f_pass(f_pass), .crc_pass(crc_pass), .sig_en(sig_en), .gstuff(gstuff),
        .dl_sel(dl_sel), .blue_en(blue_en), .yel_en(yel_en), .dl_ext(dl_ext),
        .dl_word(dl_word), .stuff_mask(stuff_mask), .sig_mask(sig_mask),
        .sig_val(sig_val), .ser_out(ser_out)
    );

    task automatic check(logic act, logic exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: ser_out=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pop expected items when due and compare
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            it = sbq.pop_front();
            check(ser_out, it.b, it.tag);
        end
    end

    // Drive one bit and push its expected output; also runs the CRC model
    task automatic drive(logic din, logic fs, logic e, string tag, logic is_f);
        logic d, fb;
        ser_in = din;
        fsync  = fs;
        sbq.push_back('{e, tag, cyc + 8});
        if (fs) begin m_prev = m_st; m_st = '0; end
        d  = is_f ? 1'b1 : e;
        fb = d ^ m_st[5];
        m_st = {m_st[4:0], 1'b0} ^ (fb ? 6'b000011 : 6'b0);
    endtask

    task automatic send_sf();
        logic [5:0] pat = 6'b110100;  // 0,0,1,0,1,1 by index
        for (int f = 0; f < 24; f++) begin
            logic fin, e;
            string tg;
            @(negedge clk);
            if (f == 0) begin
                f_pass = p_fp; crc_pass = p_cp; sig_en = p_se; gstuff = p_gs;
                dl_sel = p_ds; blue_en = p_bl; yel_en = p_ye;
            end
            fin = 1'($urandom);
            dl_ext = 1'($urandom);
            if (!yel_en) m_y = '0;
            if (f % 4 == 3) begin
                e = f_pass ? fin : pat[f / 4]; tg = f_pass ? "R4" : "R2";
            end else if (f % 4 == 1) begin
                e = crc_pass ? fin : m_prev[5 - f / 4]; tg = crc_pass ? "R5" : "R3";
            end else begin
                if (f_pass) begin e = fin; tg = "R4"; end
                else if (yel_en) begin e = m_y[3]; tg = "R10"; end
                else begin e = dl_sel ? dl_ext : dl_word[f / 2]; tg = "R6"; end
                if (yel_en) m_y = m_y + 4'd1;
            end
            if (blue_en) begin e = 1'b1; tg = "R11"; end
            drive(fin, f == 0, e, tg, 1'b1);
            for (int c = 0; c < 24; c++) begin
                logic [7:0] b, eb;
                logic sigf, zero;
                case (c % 4)
                    0: b = 8'h00;
                    1: b = 8'h01;
                    2: b = 8'h80;
                    default: b = 8'($urandom);
                endcase
                eb = b;
                sigf = (f % 6 == 5) && sig_en && sig_mask[c];
                if (sigf) eb[0] = sig_val[4 * c + 3 - f / 6];
                zero = (eb == 8'h00);
                if (zero && (gstuff || stuff_mask[c])) eb[1] = 1'b1;
                if (blue_en) eb = 8'hFF;
                for (int i = 7; i >= 0; i--) begin
                    string bt;
                    bt = "R1";
                    if (blue_en) bt = "R11";
                    else if (i == 0 && sigf) bt = "R7";
                    else if (i == 1) bt = gstuff ? "R9" : "R8";
                    @(negedge clk);
                    drive(b[i], 1'b0, eb[i], bt, 1'b0);
                end
            end
        end
    endtask

    task automatic cfg(logic fp, cp, se, gs, ds, bl, ye);
        p_fp = fp; p_cp = cp; p_se = se; p_gs = gs; p_ds = ds; p_bl = bl; p_ye = ye;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        dl_word = 12'hA5C;
        stuff_mask = 24'h0F0F0F;
        sig_mask = 24'hFFF000;
        sig_val = {$urandom, $urandom, $urandom};
        repeat (4) @(negedge clk);
        check(ser_out, 1'b0, "R1 reset");
        rst_n = 1'b1;
        ser_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ser_out, 1'b0, "R1 prelock");
        end
        cfg(0, 0, 0, 0, 0, 0, 0); send_sf();   // R2 R3 R6 R8 baseline
        cfg(0, 0, 1, 0, 1, 0, 0); send_sf();   // R7 signaling, R6 external link
        cfg(1, 1, 1, 1, 0, 0, 0); send_sf();   // R4 R5 pass-through, R9 global stuff
        cfg(0, 0, 1, 0, 1, 0, 1); send_sf();   // R10 yellow
        cfg(0, 0, 0, 0, 0, 0, 1); send_sf();   // R10 yellow continues across edge
        cfg(0, 0, 0, 0, 0, 1, 0); send_sf();   // R11 blue
        cfg(0, 0, 0, 0, 0, 0, 0); send_sf();   // R3 CRC of the all-ones superframe
        @(negedge clk);
        fsync = 1'b0;
        repeat (12) @(negedge clk);
        n_chk++;
        if (sbq.size() != 0) begin
            n_err++;
            $display("FAIL R1: %0d items left, expected 0", sbq.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule